// File: doc/BRIEF.md
# Segment Effective Base Tracker

This block holds, for each of eight segments, the architectural base and the effective base that address generation actually adds. Software-visible base writes and code-segment attribute writes arrive as one stream of write beats. The block keeps each effective base up to date from those beats and from a `lma_i` level input that says long addressing is active. When long addressing is active and the code segment carries its long attribute, the processor is in 64-bit mode.

There are two segment classes. The data-path classic segments (ES, CS, SS, DS) have their effective base forced to zero while in 64-bit mode. Their architectural base still records every write, so leaving 64-bit mode can restore the effective base. The pass-through segments (FS, GS, TR, IDTR) copy every written base into the effective base in any mode. The write stream never back-pressures: `wr_ready_o` is held high, and a beat is consumed on every rising clock edge where `wr_valid_i` is high.

Top module: `seg_eff_base_tracker`

## Requirements
- R1: After reset every effective base reads zero and the code-segment long attribute is clear, so `mode64_o` is low.
- R2: A base beat (`wr_kind_i`=0) to a pass-through segment (select 4=FS, 5=GS, 6=TR, 7=IDTR) appears on that segment's effective base one cycle later, whatever the mode.
- R3: A base beat to a classic segment (select 0=ES, 1=CS, 2=SS, 3=DS) outside 64-bit mode appears on that effective base one cycle later.
- R4: A base beat to a classic segment while in 64-bit mode leaves its effective base unchanged.
- R5: An attribute beat (`wr_kind_i`=1) whose data bit LONG_BIT (default bit 0) is 1 while the stored long attribute is 0 clears all four classic effective bases, whatever `lma_i` is.
- R6: An attribute beat whose long bit is 0 while the stored attribute is 1 reloads each classic effective base from its architectural base. This includes values written while in 64-bit mode.
- R7: An attribute beat that does not change the stored long attribute leaves every effective base unchanged.
- R8: Attribute beats never alter pass-through effective bases.
- R9: `wr_ready_o` is always 1. No state changes in a cycle where `wr_valid_i` is 0.
- R10: `mode64_o` equals `lma_i` AND the stored long attribute. The stored attribute takes the long bit of each attribute beat one cycle after the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lma_i | input | 1 | Long addressing active level |
| wr_valid_i | input | 1 | Write beat valid |
| wr_ready_o | output | 1 | Write beat ready, constant 1 |
| wr_kind_i | input | 1 | 0 base write, 1 code-segment attribute write |
| wr_sel_i | input | 3 | Segment select for base writes |
| wr_data_i | input | 64 | Base value or attribute word |
| mode64_o | output | 1 | 64-bit mode indicator |
| eff_base_o | output | 8x64 | Effective bases, index equals segment select |

## Verification
On every cycle, assertions inside each base slot check four things: a pass-through copy lands after one cycle, a classic base is held during a 64-bit write, a long-attribute set produces zero, and a long-attribute clear restores the saved base. The mode register has an assertion that the stored attribute follows each attribute beat. Some behaviour can only be shown by bench scenarios that cross a mode boundary. One case is a classic base written inside 64-bit mode that reappears after exit. Another is an attribute set while `lma_i` is low, which still zeroes the bases but leaves `mode64_o` low, so later classic writes take effect.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned SEG_W       = 64;
  localparam int unsigned SEG_COUNT   = 8;
  localparam int unsigned CLASSIC_CNT = 4;
  localparam int unsigned SEL_W       = $clog2(SEG_COUNT);

  typedef enum logic {
    BEAT_BASE = 1'b0,
    BEAT_ATTR = 1'b1
  } beat_kind_e;
endpackage

// File: rtl/seg_mode_ctl.sv
module seg_mode_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lma_i,
  input  logic attr_we_i,
  input  logic attr_long_i,
  output logic long_q_o,
  output logic mode64_o
);
  logic long_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        long_q <= 1'b0;
    else if (attr_we_i) long_q <= attr_long_i;
  end

  assign long_q_o = long_q;
  assign mode64_o = lma_i & long_q;

  p_attr_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_we_i |=> long_q == $past(attr_long_i));
endmodule

// File: rtl/seg_wr_decode.sv
module seg_wr_decode
  import seg_pkg::*;
(
  input  logic                 wr_valid_i,
  input  logic                 wr_kind_i,
  input  logic [SEL_W-1:0]     wr_sel_i,
  input  logic                 attr_long_i,
  input  logic                 long_q_i,
  output logic [SEG_COUNT-1:0] base_we_o,
  output logic                 attr_we_o,
  output logic                 zero_evt_o,
  output logic                 restore_evt_o
);
  logic base_beat;

  assign base_beat = wr_valid_i && (beat_kind_e'(wr_kind_i) == BEAT_BASE);
  assign attr_we_o = wr_valid_i && (beat_kind_e'(wr_kind_i) == BEAT_ATTR);

  always_comb begin
    base_we_o = '0;
    if (base_beat) base_we_o[wr_sel_i] = 1'b1;
  end

  assign zero_evt_o    = attr_we_o &&  attr_long_i && !long_q_i;
  assign restore_evt_o = attr_we_o && !attr_long_i &&  long_q_i;

  always_comb begin
    a_one_event_r9: assert ($onehot0({|base_we_o, attr_we_o}));
  end
endmodule

// File: rtl/seg_base_slot.sv
module seg_base_slot #(
  parameter int unsigned W       = 64,
  parameter bit          CLASSIC = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         base_we_i,
  input  logic [W-1:0] data_i,
  input  logic         mode64_i,
  input  logic         zero_evt_i,
  input  logic         restore_evt_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] eff_q;

  generate
    if (CLASSIC) begin : g_classic
      logic [W-1:0] arch_q;

      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          arch_q <= '0;
          eff_q  <= '0;
        end else begin
          if (base_we_i) arch_q <= data_i;
          if (zero_evt_i)                     eff_q <= '0;
          else if (restore_evt_i)             eff_q <= arch_q;
          else if (base_we_i && !mode64_i)    eff_q <= data_i;
        end
      end

      p_hold_in64_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (base_we_i && mode64_i) |=> $stable(eff_q));
      p_zero_on_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_evt_i |=> eff_q == '0);
      p_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restore_evt_i |=> eff_q == $past(arch_q));
    end else begin : g_pass
      logic unused_ctl;
      assign unused_ctl = mode64_i ^ zero_evt_i ^ restore_evt_i;

      always_ff @(posedge clk_i) begin
        if (!rst_ni)        eff_q <= '0;
        else if (base_we_i) eff_q <= data_i;
      end

      p_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        base_we_i |=> eff_q == $past(data_i));
      p_attr_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !base_we_i |=> $stable(eff_q));
    end
  endgenerate

  assign eff_o = eff_q;
endmodule

// File: rtl/seg_eff_base_tracker.sv
module seg_eff_base_tracker
  import seg_pkg::*;
#(
  parameter int unsigned LONG_BIT = 0
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            lma_i,
  input  logic                            wr_valid_i,
  output logic                            wr_ready_o,
  input  logic                            wr_kind_i,
  input  logic [SEL_W-1:0]                wr_sel_i,
  input  logic [SEG_W-1:0]                wr_data_i,
  output logic                            mode64_o,
  output logic [SEG_COUNT-1:0][SEG_W-1:0] eff_base_o
);
  logic [SEG_COUNT-1:0] base_we;
  logic attr_we, zero_evt, restore_evt, long_q, mode64;

  assign wr_ready_o = 1'b1;

  seg_wr_decode u_dec (
    .wr_valid_i    (wr_valid_i),
    .wr_kind_i     (wr_kind_i),
    .wr_sel_i      (wr_sel_i),
    .attr_long_i   (wr_data_i[LONG_BIT]),
    .long_q_i      (long_q),
    .base_we_o     (base_we),
    .attr_we_o     (attr_we),
    .zero_evt_o    (zero_evt),
    .restore_evt_o (restore_evt)
  );

  seg_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lma_i       (lma_i),
    .attr_we_i   (attr_we),
    .attr_long_i (wr_data_i[LONG_BIT]),
    .long_q_o    (long_q),
    .mode64_o    (mode64)
  );

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_slot
    seg_base_slot #(
      .W       (SEG_W),
      .CLASSIC (s < CLASSIC_CNT)
    ) u_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .base_we_i     (base_we[s]),
      .data_i        (wr_data_i),
      .mode64_i      (mode64),
      .zero_evt_i    (zero_evt),
      .restore_evt_i (restore_evt),
      .eff_o         (eff_base_o[s])
    );
  end

  assign mode64_o = mode64;

  p_idle_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(eff_base_o));
endmodule

// File: tb/seg_eff_base_tracker_tb_top.sv
module seg_eff_base_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lma = 1'b0, wr_valid = 1'b0, wr_ready, wr_kind = 1'b0, mode64;
  logic [2:0] wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [7:0][63:0] eff;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  seg_eff_base_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lma_i(lma), .wr_valid_i(wr_valid),
    .wr_ready_o(wr_ready), .wr_kind_i(wr_kind), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .mode64_o(mode64), .eff_base_o(eff)
  );

  // fields: req[4] lma kind sel[3] data[64] chk[3] exp[64]
  localparam int NV = 11;
  localparam logic [139:0] VEC [NV] = '{
    {4'd3, 1'b0, 1'b0, 3'd0, 64'hA1A1_0000_0000_1111, 3'd0, 64'hA1A1_0000_0000_1111}, // R3
    {4'd2, 1'b0, 1'b0, 3'd4, 64'hB1B1_2222_3333_4444, 3'd4, 64'hB1B1_2222_3333_4444}, // R2
    {4'd5, 1'b0, 1'b1, 3'd0, 64'h1,                   3'd0, 64'h0},                   // R5
    {4'd4, 1'b1, 1'b0, 3'd0, 64'hA2A2_5555_6666_7777, 3'd0, 64'h0},                   // R4
    {4'd2, 1'b1, 1'b0, 3'd5, 64'hC1C1_8888_9999_AAAA, 3'd5, 64'hC1C1_8888_9999_AAAA}, // R2
    {4'd7, 1'b1, 1'b1, 3'd0, 64'hFFFF_0000_0000_0001, 3'd0, 64'h0},                   // R7
    {4'd6, 1'b1, 1'b1, 3'd0, 64'h0,                   3'd0, 64'hA2A2_5555_6666_7777}, // R6
    {4'd8, 1'b1, 1'b1, 3'd0, 64'h0,                   3'd4, 64'hB1B1_2222_3333_4444}, // R8
    {4'd5, 1'b0, 1'b1, 3'd0, 64'h1,                   3'd0, 64'h0},                   // R5
    {4'd3, 1'b0, 1'b0, 3'd1, 64'hD1D1_0101_0202_0303, 3'd1, 64'hD1D1_0101_0202_0303}, // R3
    {4'd6, 1'b0, 1'b1, 3'd0, 64'h0,                   3'd1, 64'hD1D1_0101_0202_0303}  // R6
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic l, input logic k, input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    lma = l; wr_kind = k; wr_sel = s; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 8; s++) check("R1", eff[s], 64'h0);
    check("R1", {63'h0, mode64}, 64'h0);
    check("R9", {63'h0, wr_ready}, 64'h1);

    for (int i = 0; i < NV; i++) begin
      beat(VEC[i][135], VEC[i][134], VEC[i][133:131], VEC[i][130:67]);
      check($sformatf("R%0d", VEC[i][139:136]), eff[VEC[i][66:64]], VEC[i][63:0]);
    end

    // R2: IDTR copy in 64-bit mode
    beat(1'b0, 1'b1, 3'd0, 64'h1);
    beat(1'b1, 1'b0, 3'd7, 64'h7777_0000_1234_5678);
    check("R2", eff[7], 64'h7777_0000_1234_5678);
    // R10: mode64 with lma high and long set, then lma low
    check("R10", {63'h0, mode64}, 64'h1);
    lma = 1'b0; #1;
    check("R10", {63'h0, mode64}, 64'h0);
    // R9: idle beat with data present changes nothing
    @(negedge clk);
    wr_kind = 1'b0; wr_sel = 3'd2; wr_data = 64'hDEAD; wr_valid = 1'b0;
    @(negedge clk);
    check("R9", eff[2], 64'h0);
    check("R9", eff[7], 64'h7777_0000_1234_5678);
    // R4 then R6: SS written while in 64-bit mode restored on exit
    beat(1'b1, 1'b0, 3'd2, 64'h5555_AAAA_5555_AAAA);
    check("R4", eff[2], 64'h0);
    beat(1'b1, 1'b1, 3'd0, 64'h0);
    check("R6", eff[2], 64'h5555_AAAA_5555_AAAA);
    check("R8", eff[7], 64'h7777_0000_1234_5678);
    // R1: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", eff[2], 64'h0);
    check("R1", eff[7], 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule